// File: doc/BRIEF.md
# Keypad Tuning Parameter Controller

This block turns five active-low push buttons and a mode pin into two tuning settings for a waveform generator. The first setting is a 16-bit frequency register that the keys count down in decimal steps. The second is a phase register counted in 5-degree units. Each distinct press changes at most one setting. When all keys are released after a press, the block sends both settings downstream as a fixed sequence of four register writes over a small parallel port. It also raises a one-cycle refresh pulse for the display logic.

The buttons are assumed debounced. Each button and the mode pin pass through a two-flop synchronizer before any decision is made. A press that arrives while a write sequence is running takes effect as soon as the sequence ends, provided the key is still held.

Top module: `keypad_tuner`

## Requirements
- R1: Out of reset the frequency is 50000 and the phase is 0. The port is idle: `wr_sel_o`=00, `wr_data_o`=0, strobe low, busy low. One write sequence carrying these values is issued once after reset.
- R2: With `mode_i` high (frequency mode), bits 4, 3, 2, 1 and 0 of `key_n_i` subtract 10000, 1000, 100, 10 and 1 respectively from the frequency.
- R3: A frequency subtraction that falls below zero leaves 50000 in the register instead of the wrapped value.
- R4: With `mode_i` low (phase mode), key bit 1 adds 9 to the phase and key bit 0 adds 1. Any sum of 72 or more becomes 0.
- R5: In phase mode, key bits 2, 3 and 4 change nothing and start no write sequence.
- R6: A press of two or more keys at once changes nothing and starts no write sequence.
- R7: One press makes exactly one change, however long it is held. The write sequence starts only once all keys are released.
- R8: A write sequence is four writes in this order: select 11 with the phase (zero-extended), select 01 with frequency bits 15:8, select 10 with frequency bits 7:0, then select 00 with data 0.
- R9: For each write, the select and data lines are driven one cycle before the strobe. The strobe is high for exactly one cycle, and select and data do not change while it is high.
- R10: `busy_o` is high for the whole write sequence, including every strobe cycle. `refresh_o` pulses for one cycle as each sequence begins.
- R11: A key pressed while `busy_o` is high is acted on after the sequence ends, if it is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_n_i | input | 5 | Push buttons, active low; bit 0 is the finest step |
| mode_i | input | 1 | 1 = frequency mode, 0 = phase mode |
| wr_sel_o | output | 2 | Register select for the downstream write |
| wr_data_o | output | 8 | Write data |
| wr_stb_o | output | 1 | One-cycle write strobe |
| busy_o | output | 1 | High while a write sequence runs |
| refresh_o | output | 1 | One-cycle display refresh pulse |

## Verification
The hardest case to reach from the ports is a key press that coincides with a running write sequence. The stimulus reaches it by pressing a key in the first cycles after reset, while the automatic post-reset sequence is still running. The key is held well past that sequence, and the bench then expects exactly one change, carried in a second sequence after release. The wrap corners are reached by long key runs. The frequency is driven down to 0 before one more subtraction, and the phase is walked to 63 and 71 before the step that crosses 72.

// File: rtl/kt_pkg.sv
package kt_pkg;
  localparam int NUM_KEYS = 5;
  localparam int FREQ_W   = 16;
  localparam int PHASE_W  = 7;
  localparam int BUS_W    = 8;
  localparam int SEL_W    = 2;

  // decimal weight of key idx: 10**idx
  function automatic logic [FREQ_W-1:0] key_weight(input int unsigned idx);
    logic [FREQ_W-1:0] w;
    w = 1;
    for (int i = 0; i < NUM_KEYS; i++)
      if (i < int'(idx)) w = FREQ_W'(w * 10);
    return w;
  endfunction

  // subtract; anything landing above the cap came from an unsigned wrap
  function automatic logic [FREQ_W-1:0] freq_next(input logic [FREQ_W-1:0] cur,
                                                  input int unsigned idx,
                                                  input logic [FREQ_W-1:0] cap);
    logic [FREQ_W-1:0] diff;
    diff = cur - key_weight(idx);
    return (diff > cap) ? cap : diff;
  endfunction

  function automatic logic [PHASE_W-1:0] phase_next(input logic [PHASE_W-1:0] cur,
                                                    input logic [PHASE_W-1:0] inc,
                                                    input logic [PHASE_W:0] limit);
    logic [PHASE_W:0] sum;
    sum = {1'b0, cur} + {1'b0, inc};
    return (sum >= limit) ? '0 : sum[PHASE_W-1:0];
  endfunction

  function automatic int unsigned hot_index(input logic [NUM_KEYS-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < NUM_KEYS; i++)
      if (v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/kt_sync.sv
module kt_sync #(
  parameter int          WIDTH   = 5,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL[b]}};
      else        sh <= {sh[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/kt_keyproc.sv
module kt_keyproc
  import kt_pkg::*;
#(
  parameter logic [FREQ_W-1:0]  FREQ_INIT = 16'd50000,
  parameter logic [FREQ_W-1:0]  FREQ_CAP  = 16'd50000,
  parameter logic [PHASE_W:0]   PHASE_MOD = 8'd72,
  parameter logic [PHASE_W-1:0] FINE_INC  = 7'd1,
  parameter logic [PHASE_W-1:0] COARSE_INC = 7'd9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] pressed_i,
  input  logic                freq_mode_i,
  input  logic                hold_i,
  output logic [FREQ_W-1:0]   freq_o,
  output logic [PHASE_W-1:0]  phase_o,
  output logic                act_o,
  output logic                rel_o
);
  logic latch_q;
  logic single;
  logic usable;

  assign single = $onehot(pressed_i);
  assign usable = single && (freq_mode_i || pressed_i[0] || pressed_i[1]);
  assign act_o  = usable && !latch_q && !hold_i;
  assign rel_o  = latch_q && (pressed_i == '0) && !hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      freq_o  <= FREQ_INIT;
      phase_o <= '0;
    end else if (act_o) begin
      latch_q <= 1'b1;
      if (freq_mode_i)
        freq_o <= freq_next(freq_o, hot_index(pressed_i), FREQ_CAP);
      else
        phase_o <= phase_next(phase_o, pressed_i[1] ? COARSE_INC : FINE_INC, PHASE_MOD);
    end else if (rel_o) begin
      latch_q <= 1'b0;
    end
  end
endmodule

// File: rtl/kt_burst.sv
module kt_burst
  import kt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [FREQ_W-1:0]  freq_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic [BUS_W-1:0]   data_o,
  output logic               stb_o,
  output logic               busy_o
);
  localparam int STEPS = 4;
  localparam int STEP_W = $clog2(STEPS);

  logic [STEP_W-1:0] step_q;
  logic              strobe_phase_q;
  logic [STEP_W-1:0] load_step;
  logic [SEL_W-1:0]  nxt_sel;
  logic [BUS_W-1:0]  nxt_data;

  assign load_step = start_i ? '0 : STEP_W'(step_q + 1'b1);

  always_comb begin
    unique case (load_step)
      2'd0:    begin nxt_sel = 2'b11; nxt_data = BUS_W'(phase_i);          end
      2'd1:    begin nxt_sel = 2'b01; nxt_data = freq_i[FREQ_W-1 -: BUS_W]; end
      2'd2:    begin nxt_sel = 2'b10; nxt_data = freq_i[BUS_W-1:0];         end
      default: begin nxt_sel = 2'b00; nxt_data = '0;                        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o         <= 1'b0;
      step_q         <= '0;
      strobe_phase_q <= 1'b0;
      sel_o          <= '0;
      data_o         <= '0;
      stb_o          <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o         <= 1'b1;
        step_q         <= '0;
        strobe_phase_q <= 1'b0;
        sel_o          <= nxt_sel;
        data_o         <= nxt_data;
      end
    end else if (!strobe_phase_q) begin
      stb_o          <= 1'b1;
      strobe_phase_q <= 1'b1;
    end else begin
      stb_o          <= 1'b0;
      strobe_phase_q <= 1'b0;
      if (step_q == STEP_W'(STEPS-1)) begin
        busy_o <= 1'b0;
      end else begin
        step_q <= load_step;
        sel_o  <= nxt_sel;
        data_o <= nxt_data;
      end
    end
  end
endmodule

// File: rtl/keypad_tuner.sv
module keypad_tuner
  import kt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] key_n_i,
  input  logic                mode_i,
  output logic [SEL_W-1:0]    wr_sel_o,
  output logic [BUS_W-1:0]    wr_data_o,
  output logic                wr_stb_o,
  output logic                busy_o,
  output logic                refresh_o
);
  logic [NUM_KEYS-1:0] key_s;
  logic [0:0]          mode_s;
  logic [NUM_KEYS-1:0] pressed;
  logic [FREQ_W-1:0]   freq_q;
  logic [PHASE_W-1:0]  phase_q;
  logic                act_evt;
  logic                rel_evt;
  logic                start_evt;
  logic                init_pend_q;

  kt_sync #(.WIDTH(NUM_KEYS), .STAGES(2), .RST_VAL('1)) u_key_sync (
    .clk(clk), .rst_n(rst_n), .d_i(key_n_i), .q_o(key_s));

  kt_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b1)) u_mode_sync (
    .clk(clk), .rst_n(rst_n), .d_i(mode_i), .q_o(mode_s));

  assign pressed = ~key_s;

  kt_keyproc u_keyproc (
    .clk(clk), .rst_n(rst_n), .pressed_i(pressed), .freq_mode_i(mode_s[0]),
    .hold_i(busy_o), .freq_o(freq_q), .phase_o(phase_q),
    .act_o(act_evt), .rel_o(rel_evt));

  assign start_evt = (init_pend_q || rel_evt) && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_pend_q <= 1'b1;
      refresh_o   <= 1'b0;
    end else begin
      refresh_o <= start_evt;
      if (start_evt) init_pend_q <= 1'b0;
    end
  end

  kt_burst u_burst (
    .clk(clk), .rst_n(rst_n), .start_i(start_evt), .phase_i(phase_q),
    .freq_i(freq_q), .sel_o(wr_sel_o), .data_o(wr_data_o),
    .stb_o(wr_stb_o), .busy_o(busy_o));
endmodule

// File: rtl/kt_checker.sv
module kt_checker
  import kt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [SEL_W-1:0]   wr_sel,
  input logic [BUS_W-1:0]   wr_data,
  input logic               wr_stb,
  input logic               busy,
  input logic               refresh,
  input logic [FREQ_W-1:0]  freq,
  input logic [PHASE_W-1:0] phase,
  input logic               act_evt,
  input logic               rel_evt
);
  logic [1:0] ord_q;
  logic [SEL_W-1:0] exp_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ord_q <= '0;
    else if (refresh) ord_q <= '0;
    else if (wr_stb)  ord_q <= ord_q + 1'b1;
  end

  always_comb begin
    unique case (ord_q)
      2'd0: exp_sel = 2'b11;
      2'd1: exp_sel = 2'b01;
      2'd2: exp_sel = 2'b10;
      default: exp_sel = 2'b00;
    endcase
  end

  // R8
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_sel == exp_sel));
  // R8
  last_write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_sel == 2'b00) |-> (wr_data == '0));
  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R9
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($stable(wr_sel) && $stable(wr_data)));
  // R10
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> busy);
  // R10
  refresh_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> (busy && !$past(busy)));
  // R3
  freq_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq <= 16'd50000);
  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase < 7'd72);
  // R11
  act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt |-> !busy);
  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt |=> !act_evt);
  // R7
  release_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> refresh);
endmodule

bind keypad_tuner kt_checker u_kt_checker (
  .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel_o), .wr_data(wr_data_o),
  .wr_stb(wr_stb_o), .busy(busy_o), .refresh(refresh_o), .freq(freq_q),
  .phase(phase_q), .act_evt(act_evt), .rel_evt(rel_evt));

// File: tb/test_keypad_tuner.sv
module test_keypad_tuner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] key_n = 5'h1f;
  logic       mode = 1'b1;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       wr_stb, busy, refresh;

  always #4 clk = ~clk;

  keypad_tuner i_keypad_tuner (
    .clk(clk), .rst_n(rst_n), .key_n_i(key_n), .mode_i(mode),
    .wr_sel_o(wr_sel), .wr_data_o(wr_data), .wr_stb_o(wr_stb),
    .busy_o(busy), .refresh_o(refresh));

  int checks = 0, fails = 0;
  int m_freq = 50000, m_phase = 0;
  int bursts_exp = 0, refresh_seen = 0, strobes_seen = 0;
  int cycles = 0;
  bit done = 0;
  int q_sel[$], q_data[$];
  string q_tag[$];
  logic [1:0] prev_sel = '0;
  logic [7:0] prev_data = '0;
  logic prev_stb = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_burst(input string tag);
    q_sel.push_back(3); q_data.push_back(m_phase);            q_tag.push_back(tag);
    q_sel.push_back(1); q_data.push_back((m_freq >> 8) & 255); q_tag.push_back(tag);
    q_sel.push_back(2); q_data.push_back(m_freq & 255);        q_tag.push_back(tag);
    q_sel.push_back(0); q_data.push_back(0);                   q_tag.push_back(tag);
    bursts_exp++;
  endtask

  // reference model compared every clock, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (refresh) refresh_seen++;
      if (wr_stb) begin
        strobes_seen++;
        if (q_sel.size() == 0) begin
          check(0, "R8 unexpected strobe", wr_sel, -1);
        end else begin
          int es, ed;
          string tg;
          es = q_sel.pop_front(); ed = q_data.pop_front(); tg = q_tag.pop_front();
          check(wr_sel == es, {"R8 select ", tg}, wr_sel, es);
          check(wr_data == ed, {"R8 data ", tg}, wr_data, ed);
        end
        check(busy, "R10 busy at strobe", busy, 1);
        check(!prev_stb, "R9 strobe width", prev_stb, 0);
        check(wr_sel == prev_sel && wr_data == prev_data, "R9 setup before strobe",
              {wr_sel, wr_data}, {prev_sel, prev_data});
      end
    end
    prev_sel = wr_sel; prev_data = wr_data; prev_stb = wr_stb;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual %0d expected 0", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic set_mode(input logic m);
    @(negedge clk); mode = m;
    repeat (4) @(negedge clk);
  endtask

  // press the keys in mask for hold cycles, release, let any burst finish
  task automatic press(input logic [4:0] mask, input int hold, input string tag,
                       input bit idle_hold);
    bit one, valid;
    int k, s0, r0;
    one = ($countones(mask) == 1);
    k = 0;
    for (int i = 0; i < 5; i++) if (mask[i]) k = i;
    valid = one && (mode || k <= 1);
    s0 = strobes_seen; r0 = refresh_seen;
    @(negedge clk); key_n = ~mask;
    repeat (hold) @(negedge clk);
    if (idle_hold) check(strobes_seen == s0, "R7 no write while held", strobes_seen, s0);
    if (valid) begin
      if (mode) begin
        int w;
        w = 1;
        for (int i = 0; i < k; i++) w = w * 10;
        m_freq = m_freq - w;
        if (m_freq < 0) m_freq = 50000;
      end else begin
        m_phase = m_phase + ((k == 1) ? 9 : 1);
        if (m_phase >= 72) m_phase = 0;
      end
      push_burst(tag);
    end
    key_n = 5'h1f;
    repeat (20) @(negedge clk);
    if (!valid) begin
      check(strobes_seen == s0, {"no-effect strobes ", tag}, strobes_seen, s0);
      check(refresh_seen == r0, {"no-effect refresh ", tag}, refresh_seen, r0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(wr_sel == 0 && wr_data == 0, "R1 reset bus", {wr_sel, wr_data}, 0);
    check(!wr_stb && !busy && !refresh, "R1 reset controls", {wr_stb, busy, refresh}, 0);
    push_burst("R1");
    rst_n = 1'b1;
    // R11: pressed during the post-reset burst and held past it
    press(5'b10000, 30, "R11", 0);
    check(refresh_seen == 2, "R11 one deferred action", refresh_seen, 2);
    // R2 weights
    press(5'b01000, 8, "R2", 1);
    press(5'b00100, 8, "R2", 1);
    press(5'b00010, 8, "R2", 1);
    press(5'b00001, 8, "R2", 1);
    // R7 long hold gives a single step
    press(5'b01000, 60, "R7", 1);
    // drive to 0 then underflow (R3)
    while (m_freq >= 10000) press(5'b10000, 6, "R2", 1);
    while (m_freq >= 1000)  press(5'b01000, 6, "R2", 1);
    while (m_freq >= 100)   press(5'b00100, 6, "R2", 1);
    while (m_freq >= 10)    press(5'b00010, 6, "R2", 1);
    while (m_freq > 0)      press(5'b00001, 6, "R2", 1);
    press(5'b00001, 6, "R3", 1);
    check(m_freq == 50000, "R3 model wrap", m_freq, 50000);
    press(5'b10000, 6, "R3", 1);
    press(5'b10000, 6, "R2", 1);
    press(5'b10000, 6, "R2", 1);
    press(5'b10000, 6, "R2", 1);
    press(5'b10000, 6, "R2", 1);
    press(5'b10000, 6, "R3", 1);
    // R6 multi-key in frequency mode
    press(5'b00011, 8, "R6", 1);
    press(5'b11000, 8, "R6", 1);
    // phase mode
    set_mode(1'b0);
    for (int i = 0; i < 7; i++) press(5'b00010, 6, "R4", 1);
    press(5'b00010, 6, "R4", 1);      // 63+9 -> 0
    for (int i = 0; i < 7; i++) press(5'b00010, 6, "R4", 1);
    for (int i = 0; i < 8; i++) press(5'b00001, 6, "R4", 1);   // 71
    press(5'b00001, 6, "R4", 1);      // 71+1 -> 0
    press(5'b00100, 8, "R5", 1);
    press(5'b01000, 8, "R5", 1);
    press(5'b10000, 8, "R5", 1);
    press(5'b00001, 6, "R5", 1);      // shows phase unchanged by the above
    press(5'b00011, 8, "R6", 1);
    repeat (20) @(negedge clk);
    check(q_sel.size() == 0, "R8 all writes seen", q_sel.size(), 0);
    check(refresh_seen == bursts_exp, "R10 refresh per burst", refresh_seen, bursts_exp);
    check(strobes_seen == 4 * bursts_exp, "R8 four writes per burst", strobes_seen, 4 * bursts_exp);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule